// File: doc/BRIEF.md
# Modem Status and Interrupt Register

This block holds the host-readable status word of a data-pump modem. It keeps four condition flags: the data buffer is free for the host, the interleave buffer has nearly run dry, a data-quality reading is ready, and the input buffer has overflowed. It also keeps one sticky interrupt bit that collects qualifying 0-to-1 transitions of those flags. A host read of the status word clears the interrupt bit. An active-low interrupt pin is pulled low while the interrupt bit is set and interrupts are enabled.

The buffer-free flag has two kinds of cause. When the datapath reports that a task has finished, the flag is set and an interrupt is raised. A RESET task, or a change of the power-save or transmit/receive mode fields, sets the flag without an interrupt. Command writes that carry a data task clear the flag. The interleave-empty flag is produced from the datapath's interleave fill count while the block is in transmit mode. The quality-ready and overflow flags are level inputs from the datapath, registered here.

Top module: `modem_stat_irq`

## Requirements
- R1: In the cycle after a synchronous reset (rst_n low at a clock edge), the status word reads 8'h40 (only buffer-free set) and irq_n is 1.
- R2: Status word layout: bit 7 is the interrupt flag, bit 6 buffer-free, bit 5 interleave-empty, bit 4 quality-ready, bit 3 overflow; bits 2..0 always read 0. Every flag updates at the clock edge that samples its cause.
- R3: A command write whose 3-bit task code is 011 through 111 (a data task) clears buffer-free. Codes 000 (NULL) and 010 (transmit-stop) leave buffer-free and the interrupt flag unchanged.
- R4: A task_done pulse sets buffer-free. If buffer-free was 0, the interrupt flag is also set.
- R5: A command write with task code 001 (RESET), or any change of mode_psave or mode_tx relative to the previous cycle, sets buffer-free and does not set the interrupt flag.
- R6: Interleave-empty becomes 1 when mode_tx is 1 and ilv_fill is less than IBE_LIMIT (default 2). Otherwise it is 0, and it is always 0 in receive mode (mode_tx = 0).
- R7: A 0-to-1 change of interleave-empty sets the interrupt flag, except when the same cycle carries a RESET task write or a mode_psave/mode_tx change.
- R8: A 0-to-1 change of qual_rdy sets the quality-ready flag, and sets the interrupt flag only while mode_qual_irq_en is 1.
- R9: A 0-to-1 change of rx_ovf sets the overflow flag and always sets the interrupt flag.
- R10: host_rd clears the interrupt flag at the next edge. If an interrupt-setting transition occurs in the same cycle, the interrupt flag stays 1. Without a read, the flag holds.
- R11: irq_n is 0 exactly when the interrupt flag is 1 and mode_irq_en is 1; otherwise it is 1.
- R12: When causes coincide, a RESET task or mode change wins over a data-task clear, and a data-task clear wins over task_done. A losing task_done raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd | input | 1 | Host read strobe of the status word |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_task | input | 3 | Task code carried by the command write |
| mode_psave | input | 1 | Power-save mode field |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| mode_irq_en | input | 1 | Interrupt pin enable |
| mode_qual_irq_en | input | 1 | Quality-ready interrupt enable |
| task_done | input | 1 | Single-cycle task completion pulse from datapath |
| ilv_fill | input | FILL_W | Bits remaining in the interleave buffer |
| qual_rdy | input | 1 | Quality-ready level from datapath |
| rx_ovf | input | 1 | Input-buffer overflow level from datapath |
| stat_word | output | 8 | Status word |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The bench builds the block with FILL_W = 4 and the default IBE_LIMIT = 2. A random fill value therefore lands below the limit one time in eight, so the interleave-empty flag rises and falls often during the random phase. It also coincides with mode toggles and RESET tasks, which reaches the interrupt-suppression cases of R7. The directed phases push each same-cycle collision named in R10 and R12 to a known expected word.

// File: rtl/mstat_pkg.sv
// Shared constants and types for the modem status register.
// Assumes a 3-bit task code and an 8-bit status word.
package mstat_pkg;

    localparam int TASK_W    = 3;
    localparam int STAT_W    = 8;
    localparam int IRQ_BIT   = 7;
    localparam int BFREE_BIT = 6;
    localparam int IBE_BIT   = 5;
    localparam int QUAL_BIT  = 4;
    localparam int OVF_BIT   = 3;

    // Task codes that are not data tasks
    typedef enum logic [TASK_W-1:0] {
        TASK_NULL   = 3'b000,
        TASK_RESET  = 3'b001,
        TASK_TXSTOP = 3'b010
    } task_code_t;

    // Index of each level flag inside the edge detector vector
    localparam int LVL_IBE  = 0;
    localparam int LVL_QUAL = 1;
    localparam int LVL_OVF  = 2;
    localparam int N_LVL    = 3;

    // True for any task code that occupies the data buffer
    function automatic logic is_data_task(input logic [TASK_W-1:0] code);
        return (code != TASK_NULL) && (code != TASK_RESET) && (code != TASK_TXSTOP);
    endfunction

endpackage

// File: rtl/mstat_mode_watch.sv
// Detects a change of the power-save or transmit/receive mode field
// against the value held in the previous cycle.
// Assumes both fields read 0 out of reset.
module mstat_mode_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic psave,
    input  logic txsel,
    output logic changed
);
    logic psave_q;
    logic txsel_q;

    // Hold last cycle's mode fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psave_q <= 1'b0;
            txsel_q <= 1'b0;
        end else begin
            psave_q <= psave;
            txsel_q <= txsel;
        end
    end

    // Any difference counts as a mode change this cycle
    always_comb begin
        changed = (psave != psave_q) || (txsel != txsel_q);
    end
endmodule

// File: rtl/mstat_bfree.sv
// Buffer-free flag. Priority: silent set > data-task clear > completion set.
// Only a completion that finds the flag at 0 requests an interrupt.
// Assumes the completion input is a single-cycle pulse.
module mstat_bfree (
    input  logic clk,
    input  logic rst_n,
    input  logic silent_set,
    input  logic data_clr,
    input  logic done,
    output logic bfree,
    output logic irq_req
);
    logic bfree_nxt;

    // Resolve the competing causes for the next flag value
    always_comb begin
        irq_req = 1'b0;
        if (silent_set) begin
            bfree_nxt = 1'b1;
        end else if (data_clr) begin
            bfree_nxt = 1'b0;
        end else if (done) begin
            bfree_nxt = 1'b1;
            irq_req   = !bfree;
        end else begin
            bfree_nxt = bfree;
        end
    end

    // Flag register, free out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) bfree <= 1'b1;
        else        bfree <= bfree_nxt;
    end
endmodule

// File: rtl/mstat_flag_edges.sv
// Registers N level flags and reports qualified 0-to-1 transitions.
// A transition is seen in the cycle the level first reads 1,
// so the request lines up with the edge that stores the flag.
module mstat_flag_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic [N-1:0] qual,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] rise_req
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Store the current level of flag i
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= level[i];
        end

        // Rising transition of flag i, gated by its qualifier
        always_comb begin
            rise_req[i] = level[i] && !flag_q[i] && qual[i];
        end
    end
endmodule

// File: rtl/mstat_irq_acc.sv
// Sticky interrupt flag. Any request sets it; a host read clears it,
// but a request in the read cycle wins so no event is lost.
module mstat_irq_acc #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic             rd,
    output logic             irq
);
    // Set-dominant accumulate with clear on read
    always_ff @(posedge clk) begin
        if (!rst_n)     irq <= 1'b0;
        else if (|req)  irq <= 1'b1;
        else if (rd)    irq <= 1'b0;
    end
endmodule

// File: rtl/modem_stat_irq.sv
// Top of the modem status and interrupt register.
// Combines buffer-free tracking, level flag edges and the sticky
// interrupt into one status word, and drives the active-low pin.
// Assumes command and mode inputs are synchronous to clk.
module modem_stat_irq #(
    parameter int FILL_W    = 6,
    parameter int IBE_LIMIT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_rd,
    input  logic                        cmd_wr,
    input  logic [mstat_pkg::TASK_W-1:0] cmd_task,
    input  logic                        mode_psave,
    input  logic                        mode_tx,
    input  logic                        mode_irq_en,
    input  logic                        mode_qual_irq_en,
    input  logic                        task_done,
    input  logic [FILL_W-1:0]           ilv_fill,
    input  logic                        qual_rdy,
    input  logic                        rx_ovf,
    output logic [mstat_pkg::STAT_W-1:0] stat_word,
    output logic                        irq_n
);
    import mstat_pkg::*;

    localparam int N_SRC = N_LVL + 1;
    localparam logic [FILL_W-1:0] FILL_LIMIT = FILL_W'(IBE_LIMIT);

    logic             mode_chg;
    logic             silent_set;
    logic             data_clr;
    logic             bfree;
    logic             bfree_irq;
    logic [N_LVL-1:0] lvl;
    logic [N_LVL-1:0] lvl_qual;
    logic [N_LVL-1:0] lvl_q;
    logic [N_LVL-1:0] lvl_rise;
    logic [N_SRC-1:0] irq_src;
    logic             irq;

    mstat_mode_watch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .psave   (mode_psave),
        .txsel   (mode_tx),
        .changed (mode_chg)
    );

    // Classify this cycle's command and mode activity
    always_comb begin
        silent_set = mode_chg || (cmd_wr && (cmd_task == TASK_RESET));
        data_clr   = cmd_wr && is_data_task(cmd_task);
    end

    mstat_bfree u_bfree (
        .clk        (clk),
        .rst_n      (rst_n),
        .silent_set (silent_set),
        .data_clr   (data_clr),
        .done       (task_done),
        .bfree      (bfree),
        .irq_req    (bfree_irq)
    );

    // Present levels and interrupt qualifiers of the edge-tracked flags
    always_comb begin
        lvl[LVL_IBE]       = mode_tx && (ilv_fill < FILL_LIMIT);
        lvl[LVL_QUAL]      = qual_rdy;
        lvl[LVL_OVF]       = rx_ovf;
        lvl_qual[LVL_IBE]  = !silent_set;
        lvl_qual[LVL_QUAL] = mode_qual_irq_en;
        lvl_qual[LVL_OVF]  = 1'b1;
    end

    mstat_flag_edges #(
        .N (N_LVL)
    ) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl),
        .qual     (lvl_qual),
        .flag_q   (lvl_q),
        .rise_req (lvl_rise)
    );

    // Gather every interrupt request source
    always_comb begin
        irq_src = {bfree_irq, lvl_rise};
    end

    mstat_irq_acc #(
        .N_SRC (N_SRC)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_src),
        .rd    (host_rd),
        .irq   (irq)
    );

    // Assemble the status word at fixed bit positions
    always_comb begin
        stat_word            = '0;
        stat_word[IRQ_BIT]   = irq;
        stat_word[BFREE_BIT] = bfree;
        stat_word[IBE_BIT]   = lvl_q[LVL_IBE];
        stat_word[QUAL_BIT]  = lvl_q[LVL_QUAL];
        stat_word[OVF_BIT]   = lvl_q[LVL_OVF];
    end

    // Pin pulled low only for an enabled pending interrupt
    always_comb begin
        irq_n = !(irq && mode_irq_en);
    end
endmodule

// File: rtl/mstat_checker.sv
// Property checks for modem_stat_irq, attached by bind below.
// Keeps its own copy of last cycle's mode fields to tell quiet cycles.
module mstat_checker (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         host_rd,
    input logic                         cmd_wr,
    input logic [mstat_pkg::TASK_W-1:0] cmd_task,
    input logic                         mode_psave,
    input logic                         mode_tx,
    input logic                         mode_irq_en,
    input logic                         task_done,
    input logic                         rx_ovf,
    input logic [mstat_pkg::STAT_W-1:0] stat_word,
    input logic                         irq_n
);
    import mstat_pkg::*;

    logic ps_seen;
    logic tx_seen;
    logic quiet;
    logic data_wr;

    // Track previous mode fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_seen <= 1'b0;
            tx_seen <= 1'b0;
        end else begin
            ps_seen <= mode_psave;
            tx_seen <= mode_tx;
        end
    end

    // Quiet cycle: no mode change and no RESET task
    always_comb begin
        quiet   = (mode_psave == ps_seen) && (mode_tx == tx_seen) &&
                  !(cmd_wr && (cmd_task == TASK_RESET));
        data_wr = cmd_wr && is_data_task(cmd_task);
    end

    assert_data_task_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && quiet) |=> !stat_word[BFREE_BIT]);

    assert_done_sets_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (task_done && quiet && !data_wr && !stat_word[BFREE_BIT])
        |=> (stat_word[BFREE_BIT] && stat_word[IRQ_BIT]));

    assert_silent_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> stat_word[BFREE_BIT]);

    assert_rx_no_ibe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_tx |=> !stat_word[IBE_BIT]);

    assert_ovf_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !stat_word[OVF_BIT]) |=> stat_word[IRQ_BIT]);

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[IRQ_BIT] && !host_rd) |=> stat_word[IRQ_BIT]);

    assert_pin_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_irq_en |-> irq_n);

    assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_word[2:0] == 3'b000));
endmodule

bind modem_stat_irq mstat_checker u_chk (.*);

// File: tb/modem_stat_irq_test.sv
// Bench: directed collisions plus a random phase, all compared each
// cycle against a behavioural reference model.
module modem_stat_irq_test;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_rd = 1'b0, cmd_wr = 1'b0, task_done = 1'b0;
    logic [2:0]    cmd_task = 3'b000;
    logic          mode_psave = 1'b0, mode_tx = 1'b0;
    logic          mode_irq_en = 1'b0, mode_qual_irq_en = 1'b0;
    logic [FW-1:0] ilv_fill = '0;
    logic          qual_rdy = 1'b0, rx_ovf = 1'b0;
    logic [7:0]    stat_word;
    logic          irq_n;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_irq = 0, m_bf = 1, m_ibe = 0, m_dq = 0, m_ovf = 0, m_ps = 0, m_tx = 0;

    always #10 clk = ~clk;

    modem_stat_irq #(.FILL_W(FW), .IBE_LIMIT(2)) uut (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .cmd_wr(cmd_wr),
        .cmd_task(cmd_task), .mode_psave(mode_psave), .mode_tx(mode_tx),
        .mode_irq_en(mode_irq_en), .mode_qual_irq_en(mode_qual_irq_en),
        .task_done(task_done), .ilv_fill(ilv_fill), .qual_rdy(qual_rdy),
        .rx_ovf(rx_ovf), .stat_word(stat_word), .irq_n(irq_n)
    );

    // Reference model, stepped on each rising edge
    always @(posedge clk) begin
        int silent, datat, setirq, nbf, nibe;
        if (!rst_n) begin
            m_irq = 0; m_bf = 1; m_ibe = 0; m_dq = 0; m_ovf = 0; m_ps = 0; m_tx = 0;
        end else begin
            silent = ((cmd_wr && cmd_task == 3'd1) || (mode_psave != m_ps) || (mode_tx != m_tx)) ? 1 : 0;
            datat  = (cmd_wr && cmd_task >= 3'd3) ? 1 : 0;
            setirq = 0;
            if (silent != 0) nbf = 1;
            else if (datat != 0) nbf = 0;
            else if (task_done) begin
                nbf = 1;
                if (m_bf == 0) setirq = 1;
            end else nbf = m_bf;
            nibe = (mode_tx && int'(ilv_fill) < 2) ? 1 : 0;
            if (nibe == 1 && m_ibe == 0 && silent == 0) setirq = 1;
            if (qual_rdy && m_dq == 0 && mode_qual_irq_en) setirq = 1;
            if (rx_ovf && m_ovf == 0) setirq = 1;
            if (setirq != 0) m_irq = 1;
            else if (host_rd) m_irq = 0;
            m_bf = nbf; m_ibe = nibe; m_dq = int'(qual_rdy); m_ovf = int'(rx_ovf);
            m_ps = int'(mode_psave); m_tx = int'(mode_tx);
        end
    end

    function automatic logic [7:0] model_word();
        return {m_irq[0], m_bf[0], m_ibe[0], m_dq[0], m_ovf[0], 3'b000};
    endfunction

    task automatic cmp_model();
        logic exp_pin;
        exp_pin = !(m_irq[0] && mode_irq_en);
        tests++;
        if (stat_word !== model_word()) begin
            fails++;
            $display("FAIL %s model status: actual %h expected %h", cur_req, stat_word, model_word());
        end
        tests++;
        if (irq_n !== exp_pin) begin
            fails++;
            $display("FAIL R11 model pin: actual %b expected %b", irq_n, exp_pin);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cmp_model();
    endtask

    task automatic chk(input string req, input logic [7:0] exp);
        tests++;
        if (stat_word !== exp) begin
            fails++;
            $display("FAIL %s status: actual %h expected %h", req, stat_word, exp);
        end
    endtask

    task automatic chk_pin(input string req, input logic exp);
        tests++;
        if (irq_n !== exp) begin
            fails++;
            $display("FAIL %s irq_n: actual %b expected %b", req, irq_n, exp);
        end
    endtask

    task automatic wr_task(input logic [2:0] code);
        cmd_wr = 1'b1; cmd_task = code;
        step();
        cmd_wr = 1'b0; cmd_task = 3'b000;
    endtask

    task automatic rd_stat();
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        step();
        cur_req = "R1";
        chk("R1 reset", 8'h40);
        chk_pin("R1 reset", 1'b1);

        cur_req = "R3";
        wr_task(3'b011);
        chk("R3 data task clears", 8'h00);
        wr_task(3'b000);
        chk("R3 NULL ignored", 8'h00);
        wr_task(3'b010);
        chk("R3 tx-stop ignored", 8'h00);

        cur_req = "R4";
        task_done = 1'b1; step(); task_done = 1'b0;
        chk("R4 done sets with irq", 8'hC0);
        chk_pin("R11 disabled pin", 1'b1);
        mode_irq_en = 1'b1; step();
        chk_pin("R11 enabled pin", 1'b0);

        cur_req = "R10";
        rd_stat();
        chk("R10 read clears", 8'h40);
        chk_pin("R11 released", 1'b1);

        cur_req = "R5";
        wr_task(3'b111);
        chk("R3 code 7 clears", 8'h00);
        wr_task(3'b001);
        chk("R5 reset task silent", 8'h40);
        wr_task(3'b100);
        mode_psave = 1'b1; step();
        chk("R5 psave change silent", 8'h40);

        cur_req = "R6";
        ilv_fill = 4'd9; mode_tx = 1'b1; step();
        chk("R6 tx fill high", 8'h40);
        ilv_fill = 4'd1; step();
        chk("R7 ibe rise irq", 8'hE0);
        rd_stat();
        chk("R10 clear keeps ibe", 8'h60);
        ilv_fill = 4'd2; step();
        chk("R6 fill at limit", 8'h40);
        mode_tx = 1'b0; step();
        mode_tx = 1'b1; ilv_fill = 4'd0; step();
        chk("R7 ibe rise on mode change silent", 8'h60);
        mode_tx = 1'b0; step();
        chk("R6 receive mode empty fill", 8'h40);

        cur_req = "R8";
        qual_rdy = 1'b1; step();
        chk("R8 quality masked", 8'h50);
        qual_rdy = 1'b0; step();
        mode_qual_irq_en = 1'b1; qual_rdy = 1'b1; step();
        chk("R8 quality enabled", 8'hD0);
        qual_rdy = 1'b0; rd_stat();
        chk("R10 clear", 8'h40);

        cur_req = "R9";
        rx_ovf = 1'b1; step();
        chk("R9 overflow irq", 8'hC8);
        rx_ovf = 1'b0; step();
        chk("R10 hold without read", 8'hC0);
        rx_ovf = 1'b1; rd_stat();
        chk("R10 edge beats read", 8'hC8);
        rd_stat();
        chk("R10 plain read", 8'h48);

        cur_req = "R12";
        cmd_wr = 1'b1; cmd_task = 3'b101; task_done = 1'b1; step();
        chk("R12 clear beats done", 8'h08);
        cmd_task = 3'b001; step();
        chk("R12 reset task beats done", 8'h48);
        cmd_task = 3'b110; task_done = 1'b0; mode_psave = 1'b0; step();
        cmd_wr = 1'b0;
        chk("R12 mode change beats clear", 8'h48);

        cur_req = "R2 R4 R7 R9 random";
        for (int i = 0; i < 600; i++) begin
            cmd_wr           = ($urandom_range(0, 3) == 0);
            cmd_task         = 3'($urandom_range(0, 7));
            task_done        = ($urandom_range(0, 4) == 0);
            host_rd          = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) mode_psave = ~mode_psave;
            if ($urandom_range(0, 9) == 0)  mode_tx = ~mode_tx;
            ilv_fill         = FW'($urandom_range(0, 15));
            qual_rdy         = ($urandom_range(0, 2) == 0);
            rx_ovf           = ($urandom_range(0, 5) == 0);
            mode_irq_en      = ($urandom_range(0, 1) == 0);
            mode_qual_irq_en = ($urandom_range(0, 1) == 0);
            step();
        end

        finished = 1'b1;
        summary();
    end
endmodule